// File: doc/BRIEF.md
# Fault-Injectable Two-Bit Counter Table

The block is a table of two-bit saturating counters, addressed by a fixed-width index. It can serve as a direction predictor, or as hysteresis or replacement state inside a larger unit. Each counter is read at once through a read port. That port returns the two-bit state and a one-bit decision taken from the upper state bit. Counters step up or down through an update port, and the change is seen one clock later.

Every storage cell can be declared faulty. A configuration port writes, for one entry at a time, a two-bit fault mask and a two-bit stuck value. A cell whose mask bit is set reads back its stuck value. Any update stores the stuck value into that cell rather than the computed one, so the cell cannot be changed while it is faulty. A stuck upper bit pins the entry's decision for good. A stuck lower bit leaves the decision able to move, but only along a damaged path. This lets performance models and test benches see how a predictor or replacement array behaves when some of its cells are defective.

Top module: `sctab_table`

## Requirements
- R1: After reset every entry reads state 01 with the act decision (rd_act = 1), and no cell is marked faulty.
- R2: An update with upd_outcome = 1 raises the counter of a fault-free entry by one. The counter saturates at 11.
- R3: An update with upd_outcome = 0 lowers the counter of a fault-free entry by one. The counter saturates at 00.
- R4: The read port is combinational. An update is seen from the clock edge after it is presented. A read of the same index in the update's own cycle returns the old state.
- R5: When upd_en is 0, no counter changes, whatever upd_idx and upd_outcome are.
- R6: A fault configuration written through flt_we takes effect at the next clock edge. From then on, state bit k of that entry reads flt_stuck[k] wherever flt_mask[k] = 1, whatever value is stored.
- R7: While the upper bit (bit 1) of an entry is stuck, its decision rd_act stays equal to the inverse of the stuck value across any sequence of updates.
- R8: While only the lower bit (bit 0) is stuck, each update starts from the masked read value and steps by the saturating rule. The stuck value is then forced into bit 0 of the stored result. With bit 0 stuck at 0, an entry at 00 stays at 00 under increments. With bit 0 stuck at 1, one increment from 01 moves the entry to 11, and decrements keep it at 11.
- R9: When an entry's mask is cleared, its read value becomes the stored bits. Each formerly faulty cell then holds the stuck value written by the last update made while the fault was set, or its reset value if no update was made.
- R10: An update or a fault configuration on one index leaves the read value of every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | IDX_W | Index of the entry to read |
| rd_state | output | 2 | Fault-masked two-bit state of the read entry |
| rd_act | output | 1 | Decision: 1 when the upper state bit is 0 (act), 0 otherwise |
| upd_en | input | 1 | Update strobe |
| upd_idx | input | IDX_W | Index of the entry to update |
| upd_outcome | input | 1 | 1 steps the counter up, 0 steps it down |
| flt_we | input | 1 | Fault configuration write strobe |
| flt_idx | input | IDX_W | Entry whose fault bits are written |
| flt_mask | input | 2 | Per-bit fault mask, 1 marks the cell faulty |
| flt_stuck | input | 2 | Per-bit stuck value used where the mask is 1 |

## Verification
The read state and the decision are combinational in the current contents. They are due in the same cycle the index is applied. An update or a fault write changes what is read exactly one rising edge after it is presented. The bench drives every input just after a falling edge and samples outputs one nanosecond later. Each update is checked twice: once in its own cycle, where the old value is expected, and once after the next falling edge, where the new value is expected. That split pins each result to the edge at which it is due.

// File: rtl/sctab_pkg.sv
package sctab_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN   = 2'b00;
    localparam ctr_t CTR_MAX   = 2'b11;
    localparam ctr_t CTR_RESET = 2'b01;

    // Upper bit clear means the entry acts (replace / predict the first way).
    function automatic logic act_of(input ctr_t s);
        return ~s[1];
    endfunction

endpackage

// File: rtl/sctab_fault_overlay.sv
module sctab_fault_overlay #(
    parameter int W = 2
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] stuck,
    output logic [W-1:0] eff
);
    // Cells flagged by the mask are replaced by their stuck value.
    always_comb begin
        eff = (raw & ~mask) | (stuck & mask);
    end
endmodule

// File: rtl/sctab_sat_step.sv
module sctab_sat_step
    import sctab_pkg::*;
(
    input  ctr_t cur,
    input  logic up,
    output ctr_t nxt
);
    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != CTR_MAX) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_MIN) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/sctab_table.sv
module sctab_table
    import sctab_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_state,
    output logic             rd_act,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_outcome,
    input  logic             flt_we,
    input  logic [IDX_W-1:0] flt_idx,
    input  logic [1:0]       flt_mask,
    input  logic [1:0]       flt_stuck
);
    localparam int CW = 2;

    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] cnt;
        logic [DEPTH-1:0][CW-1:0] mask;
        logic [DEPTH-1:0][CW-1:0] stuck;
    } tab_t;

    localparam logic [DEPTH-1:0][CW-1:0] CNT_INIT  = {DEPTH{CTR_RESET}};
    localparam logic [DEPTH-1:0][CW-1:0] ZERO_INIT = '0;

    tab_t tab_q, tab_d;

    // Per-entry effective (fault-masked) view of the stored counters.
    logic [DEPTH-1:0][CW-1:0] eff_w;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            sctab_fault_overlay #(.W(CW)) u_ovl (
                .raw  (tab_q.cnt[g]),
                .mask (tab_q.mask[g]),
                .stuck(tab_q.stuck[g]),
                .eff  (eff_w[g])
            );
        end
    endgenerate

    // Read port.
    ctr_t       rd_eff_w;
    logic [1:0] rd_mask_w;
    always_comb begin
        rd_eff_w  = eff_w[rd_idx];
        rd_mask_w = tab_q.mask[rd_idx];
    end

    assign rd_state = rd_eff_w;
    assign rd_act   = act_of(rd_eff_w);

    // Update path: start from masked value, step, then force stuck cells.
    ctr_t       upd_cur_w;
    ctr_t       upd_step_w;
    ctr_t       upd_store_w;
    logic [1:0] upd_mask_w;
    logic [1:0] upd_stuck_w;

    always_comb begin
        upd_cur_w   = eff_w[upd_idx];
        upd_mask_w  = tab_q.mask[upd_idx];
        upd_stuck_w = tab_q.stuck[upd_idx];
    end

    sctab_sat_step u_step (
        .cur(upd_cur_w),
        .up (upd_outcome),
        .nxt(upd_step_w)
    );

    sctab_fault_overlay #(.W(CW)) u_wr_ovl (
        .raw  (upd_step_w),
        .mask (upd_mask_w),
        .stuck(upd_stuck_w),
        .eff  (upd_store_w)
    );

    always_comb begin
        tab_d = tab_q;
        if (upd_en) begin
            tab_d.cnt[upd_idx] = upd_store_w;
        end
        if (flt_we) begin
            tab_d.mask[flt_idx]  = flt_mask;
            tab_d.stuck[flt_idx] = flt_stuck;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q.cnt   <= CNT_INIT;
            tab_q.mask  <= ZERO_INIT;
            tab_q.stuck <= ZERO_INIT;
        end else begin
            tab_q <= tab_d;
        end
    end

endmodule

// File: rtl/sctab_checker.sv
module sctab_checker #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] rd_idx,
    input logic [1:0]       rd_state,
    input logic             upd_en,
    input logic [IDX_W-1:0] upd_idx,
    input logic             upd_outcome,
    input logic             flt_we,
    input logic [1:0]       rd_mask,
    input logic [1:0]       upd_mask
);
    // R2: fault-free increment seen one edge later.
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_outcome && !flt_we && upd_idx == rd_idx &&
         upd_mask == 2'b00 && rd_state != 2'b11)
        |=> (rd_idx != $past(rd_idx)) || (rd_state == $past(rd_state) + 2'd1));

    // R2: saturation at the top.
    a_r2_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_outcome && !flt_we && upd_idx == rd_idx &&
         upd_mask == 2'b00 && rd_state == 2'b11)
        |=> (rd_idx != $past(rd_idx)) || (rd_state == 2'b11));

    // R3: fault-free decrement seen one edge later.
    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_outcome && !flt_we && upd_idx == rd_idx &&
         upd_mask == 2'b00 && rd_state != 2'b00)
        |=> (rd_idx != $past(rd_idx)) || (rd_state == $past(rd_state) - 2'd1));

    // R3: saturation at the bottom.
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_outcome && !flt_we && upd_idx == rd_idx &&
         upd_mask == 2'b00 && rd_state == 2'b00)
        |=> (rd_idx != $past(rd_idx)) || (rd_state == 2'b00));

    // R5: nothing changes without a write of either kind.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !flt_we)
        |=> (rd_idx != $past(rd_idx)) || $stable(rd_state));

    // R7: a stuck upper bit pins the decision.
    a_r7_upper_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mask[1] && !flt_we)
        |=> (rd_idx != $past(rd_idx)) || (rd_state[1] == $past(rd_state[1])));

endmodule

bind sctab_table sctab_checker #(.IDX_W(IDX_W)) u_sctab_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (rd_idx),
    .rd_state   (rd_state),
    .upd_en     (upd_en),
    .upd_idx    (upd_idx),
    .upd_outcome(upd_outcome),
    .flt_we     (flt_we),
    .rd_mask    (rd_mask_w),
    .upd_mask   (upd_mask_w)
);

// File: tb/tb_sctab_table.sv
`timescale 1ns/1ps
module tb_sctab_table;
    localparam int DEPTH = 64;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [IDX_W-1:0] rd_idx;
    logic [1:0]       rd_state;
    logic             rd_act;
    logic             upd_en;
    logic [IDX_W-1:0] upd_idx;
    logic             upd_outcome;
    logic             flt_we;
    logic [IDX_W-1:0] flt_idx;
    logic [1:0]       flt_mask;
    logic [1:0]       flt_stuck;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    sctab_table #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_state(rd_state),
        .rd_act(rd_act), .upd_en(upd_en), .upd_idx(upd_idx),
        .upd_outcome(upd_outcome), .flt_we(flt_we), .flt_idx(flt_idx),
        .flt_mask(flt_mask), .flt_stuck(flt_stuck)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            n_errors = n_errors + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic chk_read(input string req, input int idx, input logic [1:0] exp);
        rd_idx = IDX_W'(idx);
        #1;
        chk(req, rd_state, exp);
        chk(req, {1'b0, rd_act}, {1'b0, ~exp[1]});
    endtask

    // Present an update; check old value in-cycle, new value after the edge.
    task automatic do_upd(input string req, input int idx, input logic up,
                          input logic [1:0] old_v, input logic [1:0] new_v);
        @(negedge clk);
        upd_en = 1'b1; upd_idx = IDX_W'(idx); upd_outcome = up;
        chk_read(req, idx, old_v);
        @(negedge clk);
        upd_en = 1'b0;
        chk_read(req, idx, new_v);
    endtask

    task automatic do_flt(input string req, input int idx, input logic [1:0] m,
                          input logic [1:0] s, input logic [1:0] old_v,
                          input logic [1:0] new_v);
        @(negedge clk);
        flt_we = 1'b1; flt_idx = IDX_W'(idx); flt_mask = m; flt_stuck = s;
        chk_read(req, idx, old_v);
        @(negedge clk);
        flt_we = 1'b0;
        chk_read(req, idx, new_v);
    endtask

    task automatic t_reset();
        chk_read("R1", 0, 2'b01);
        chk_read("R1", 17, 2'b01);
        chk_read("R1", 63, 2'b01);
    endtask

    task automatic t_count_up();
        do_upd("R2 R4", 3, 1'b1, 2'b01, 2'b10);
        do_upd("R2", 3, 1'b1, 2'b10, 2'b11);
        do_upd("R2 saturate", 3, 1'b1, 2'b11, 2'b11);
    endtask

    task automatic t_count_down();
        do_upd("R3 R4", 4, 1'b0, 2'b01, 2'b00);
        do_upd("R3 saturate", 4, 1'b0, 2'b00, 2'b00);
        do_upd("R3", 3, 1'b0, 2'b11, 2'b10);
    endtask

    task automatic t_hold();
        @(negedge clk);
        upd_en = 1'b0; upd_idx = 6'd3; upd_outcome = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_read("R5", 3, 2'b10);
        upd_outcome = 1'b0; upd_idx = 6'd4;
        @(negedge clk);
        chk_read("R5", 4, 2'b00);
    endtask

    task automatic t_isolation();
        chk_read("R10", 2, 2'b01);
        chk_read("R10", 5, 2'b01);
        do_flt("R10", 40, 2'b11, 2'b11, 2'b01, 2'b11);
        chk_read("R10", 41, 2'b01);
        chk_read("R10", 39, 2'b01);
    endtask

    task automatic t_fault_config();
        do_flt("R6", 30, 2'b11, 2'b10, 2'b01, 2'b10);
        do_flt("R6", 31, 2'b01, 2'b00, 2'b01, 2'b00);
    endtask

    task automatic t_upper_stuck();
        // bit 1 stuck at 1: decision stays "do not act"
        do_flt("R7", 10, 2'b10, 2'b10, 2'b01, 2'b11);
        do_upd("R7", 10, 1'b0, 2'b11, 2'b10);
        do_upd("R7", 10, 1'b0, 2'b10, 2'b11);
        do_upd("R7", 10, 1'b0, 2'b11, 2'b10);
        // bit 1 stuck at 0: decision stays "act"
        do_flt("R7", 11, 2'b10, 2'b00, 2'b01, 2'b01);
        do_upd("R7", 11, 1'b1, 2'b01, 2'b00);
        do_upd("R7", 11, 1'b1, 2'b00, 2'b01);
    endtask

    task automatic t_lower_stuck();
        do_flt("R8", 20, 2'b01, 2'b00, 2'b01, 2'b00);
        do_upd("R8 stuck0", 20, 1'b1, 2'b00, 2'b00);
        do_upd("R8 stuck0", 20, 1'b1, 2'b00, 2'b00);
        do_flt("R8", 21, 2'b01, 2'b01, 2'b01, 2'b01);
        do_upd("R8 stuck1", 21, 1'b1, 2'b01, 2'b11);
        do_upd("R8 stuck1", 21, 1'b0, 2'b11, 2'b11);
    endtask

    task automatic t_clear();
        do_flt("R9", 21, 2'b00, 2'b00, 2'b11, 2'b11);
        do_flt("R9", 10, 2'b00, 2'b00, 2'b10, 2'b10);
        do_flt("R9", 30, 2'b00, 2'b00, 2'b10, 2'b01);
        do_upd("R9 R2", 21, 1'b0, 2'b11, 2'b10);
    endtask

    initial begin
        rst_n = 1'b0; rd_idx = '0; upd_en = 1'b0; upd_idx = '0;
        upd_outcome = 1'b0; flt_we = 1'b0; flt_idx = '0;
        flt_mask = '0; flt_stuck = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_up();
        t_count_down();
        t_hold();
        t_isolation();
        t_fault_config();
        t_upper_stuck();
        t_lower_stuck();
        t_clear();
        @(negedge clk);
        finish_run();
    end
endmodule